// File: doc/BRIEF.md
# Stepped Volume and Soft-Mute Gain Stage

This block scales a stream of stereo 20-bit two's-complement audio samples by a programmable attenuation. A beat on the input carries one left and one right sample together, qualified by `in_valid`. A 6-bit volume code selects a gain from an uneven decibel scale. Near full level the scale moves in single-decibel steps. Toward the bottom it takes coarser steps, and its highest codes mean silence. The gain is held as a 16-bit unsigned fraction, and the sample is multiplied by it and rounded.

A mute flag does not cut the signal at once. It moves a ramp factor toward zero by one step per stereo beat over 1024 beats, and the selected gain is scaled by that factor. Clearing the flag moves the factor back up in the same way. Results leave two clock cycles after the beat that carried them, with both channels on the same output beat.

Top module: `vmg_top`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0, both output samples are 0, and the ramp factor is at full scale (1024), so the first beat is not attenuated by the mute ramp.
- R2: `out_valid` is high exactly two clock cycles after each cycle in which `in_valid` is high, and low otherwise. Both channels of a beat appear on the same output beat.
- R3: The gain for an attenuation of d dB is g(d), where g(0) = 65535 and g(d) = floor(g(d-1) * 58409 / 65536). With effective gain e, each output is floor((x * e + 32768) / 65536), where x is the signed input sample. No output has a larger magnitude than its input.
- R4: Volume codes 0 and 1 both select 0 dB. Codes 2 through 51 select (code - 1) dB of attenuation.
- R5: Codes 52 and 53 select 52 dB, codes 54 and 55 select 54 dB, and codes 56 and 57 select 57 dB.
- R6: Codes 58, 59 and 60 select 60 dB. Codes 61, 62 and 63 select gain 0, so every output sample is 0.
- R7: The volume code is sampled together with `in_valid`. A code that changes on every beat applies to exactly the beat it accompanies, and to both of that beat's channels.
- R8: A ramp factor r in 0..1024 scales the table gain to e = floor(g * r / 1024). Each beat uses the value of r held before that beat. With `mute_en` high on a beat, r then drops by 1, stopping at 0. With `mute_en` low, r rises by 1, stopping at 1024.
- R9: On cycles without `in_valid`, the ramp factor holds its value. Idle gaps inside a fade neither advance nor reset it.
- R10: After 1024 consecutive muted beats the ramp factor is 0, and every further muted beat outputs 0 on both channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks a cycle carrying one stereo beat |
| in_left | input | 20 | Left sample, two's complement |
| in_right | input | 20 | Right sample, two's complement |
| vol_code | input | 6 | Volume code, sampled with `in_valid` |
| mute_en | input | 1 | Soft-mute request, sampled with `in_valid` |
| out_valid | output | 1 | Marks a cycle carrying a scaled beat |
| out_left | output | 20 | Scaled left sample |
| out_right | output | 20 | Scaled right sample |

## Verification
The bench sweeps all 64 codes with full-scale positive and negative samples. A mistake at the step boundaries 51/52, 57/58 or 60/61 would put the wrong level on one code, or let sound through at a silent code. It changes the code on every back-to-back beat. A design that registered the code one beat late would apply the previous beat's gain, and a design that split a frame would put different gains on the two channels. It also runs a full fade down and back up with idle gaps in the middle. A ramp that stepped on clock cycles rather than on beats, used the factor after its update, or wrapped past 0 or 1024 would then drift away from the expected level beat by beat.

// File: rtl/vmg_pkg.sv
// Shared constants and elaboration-time gain computation for the volume stage.
// Assumes gains are unsigned fractions with 0 dB stored as the all-ones value.
package vmg_pkg;
    localparam int SAMPLE_W = 20;
    localparam int GAIN_W   = 16;
    localparam int CODE_W   = 6;
    localparam int RAMP_LEN = 1024;
    localparam int RAMP_W   = $clog2(RAMP_LEN) + 1;
    // -1 dB expressed as a 16-bit fraction (10^(-1/20) * 65536, floored)
    localparam longint unsigned DB_STEP = 58409;

    // Map a volume code to whole decibels of attenuation; -1 means silent.
    function automatic int code_to_db(int code);
        if (code <= 1)  return 0;
        if (code <= 51) return code - 1;
        if (code <= 53) return 52;
        if (code <= 55) return 54;
        if (code <= 57) return 57;
        if (code <= 60) return 60;
        return -1;
    endfunction

    // Gain fraction for a volume code, built by repeated 1 dB steps.
    function automatic logic [GAIN_W-1:0] code_gain(int code);
        longint unsigned g;
        int db;
        db = code_to_db(code);
        if (db < 0) return '0;
        g = (longint'(1) << GAIN_W) - 1;
        for (int i = 0; i < db; i++) g = (g * DB_STEP) >> GAIN_W;
        return GAIN_W'(g);
    endfunction
endpackage

// File: rtl/vmg_gain_rom.sv
// Volume-code to gain lookup. The table is computed while elaborating, one
// entry per code, so no constants are written out by hand.
// Assumes the code is stable in the cycle it is consumed.
module vmg_gain_rom #(
    parameter int CODE_W = vmg_pkg::CODE_W,
    parameter int GAIN_W = vmg_pkg::GAIN_W
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [GAIN_W-1:0] gain_o
);
    localparam int DEPTH = 1 << CODE_W;

    logic [GAIN_W-1:0] tbl [DEPTH];

    // One constant entry per code
    for (genvar c = 0; c < DEPTH; c++) begin : g_rom
        localparam logic [GAIN_W-1:0] GV = GAIN_W'(vmg_pkg::code_gain(c));
        assign tbl[c] = GV;
    end

    // Combinational read
    assign gain_o = tbl[code_i];
endmodule

// File: rtl/vmg_ramp.sv
// Soft-mute ramp factor. Steps once per stereo beat: down while muted, up
// otherwise, saturating at 0 and at RAMP_LEN. Output is the pre-update value.
// Assumes step_i is high for exactly one cycle per beat.
module vmg_ramp #(
    parameter int RAMP_LEN = vmg_pkg::RAMP_LEN,
    parameter int RAMP_W   = vmg_pkg::RAMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              mute_i,
    output logic [RAMP_W-1:0] ramp_o
);
    localparam logic [RAMP_W-1:0] FULL = RAMP_W'(RAMP_LEN);

    logic [RAMP_W-1:0] ramp_q;

    // Move the factor one step toward its target on each beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ramp_q <= FULL;
        end else if (step_i) begin
            if (mute_i && ramp_q != '0)
                ramp_q <= ramp_q - 1'b1;
            else if (!mute_i && ramp_q != FULL)
                ramp_q <= ramp_q + 1'b1;
        end
    end

    assign ramp_o = ramp_q;

    // R9
    ramp_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(ramp_q));

    // R8
    ramp_down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && mute_i && ramp_q != '0 |=> ramp_q == $past(ramp_q) - 1'b1);

    // R10
    ramp_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && mute_i && ramp_q == '0 |=> ramp_q == '0);
endmodule

// File: rtl/vmg_scale.sv
// One channel multiplier: signed sample times unsigned gain fraction, rounded
// half up and truncated back to the sample width, registered.
// Assumes gain never exceeds the all-ones fraction, so no saturation is needed.
module vmg_scale #(
    parameter int SAMPLE_W = vmg_pkg::SAMPLE_W,
    parameter int GAIN_W   = vmg_pkg::GAIN_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    input  logic [SAMPLE_W-1:0] x_i,
    input  logic [GAIN_W-1:0]   gain_i,
    output logic [SAMPLE_W-1:0] y_o
);
    localparam int PW = SAMPLE_W + GAIN_W + 1;
    localparam logic signed [PW-1:0] RND =
        {{(PW-GAIN_W){1'b0}}, 1'b1, {(GAIN_W-1){1'b0}}};

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] rounded;

    // Full-width signed product with rounding offset
    always_comb begin
        prod    = $signed({{(GAIN_W+1){x_i[SAMPLE_W-1]}}, x_i})
                * $signed({{SAMPLE_W{1'b0}}, 1'b0, gain_i});
        rounded = prod + RND;
    end

    // Register the scaled sample
    always_ff @(posedge clk) begin
        if (!rst_n)    y_o <= '0;
        else if (en_i) y_o <= SAMPLE_W'(rounded >>> GAIN_W);
    end

    // Magnitude of a two's-complement sample, one bit wider
    function automatic logic [SAMPLE_W:0] mag(logic [SAMPLE_W-1:0] v);
        return v[SAMPLE_W-1] ? ({1'b0, ~v} + 1'b1) : {1'b0, v};
    endfunction

    // R3
    no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> mag(y_o) <= mag($past(x_i)));

    // R6
    zero_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && gain_i == '0 |=> y_o == '0);
endmodule

// File: rtl/vmg_top.sv
// Stereo volume and soft-mute stage. Stage 1 samples the beat and forms the
// effective gain (table gain times ramp factor); stage 2 multiplies both
// channels. Latency is two cycles from in_valid to out_valid.
// Assumes RAMP_LEN is a power of two so the ramp scaling is a shift.
module vmg_top #(
    parameter int SAMPLE_W = vmg_pkg::SAMPLE_W,
    parameter int GAIN_W   = vmg_pkg::GAIN_W,
    parameter int CODE_W   = vmg_pkg::CODE_W,
    parameter int RAMP_LEN = vmg_pkg::RAMP_LEN
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    input  logic [CODE_W-1:0]   vol_code,
    input  logic                mute_en,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_left,
    output logic [SAMPLE_W-1:0] out_right
);
    localparam int RAMP_W = $clog2(RAMP_LEN) + 1;
    localparam int RSH    = $clog2(RAMP_LEN);
    localparam int GRW    = GAIN_W + RAMP_W;
    localparam int NCH    = 2;

    logic [GAIN_W-1:0]   tbl_gain;
    logic [RAMP_W-1:0]   ramp;
    logic [GRW-1:0]      gr_prod;
    logic [GAIN_W-1:0]   eff_gain;
    logic                v1_q;
    logic [GAIN_W-1:0]   g1_q;
    logic [SAMPLE_W-1:0] s1_q [NCH];
    logic [SAMPLE_W-1:0] y_q  [NCH];

    vmg_gain_rom #(.CODE_W(CODE_W), .GAIN_W(GAIN_W)) rom_i (
        .code_i (vol_code),
        .gain_o (tbl_gain)
    );

    vmg_ramp #(.RAMP_LEN(RAMP_LEN), .RAMP_W(RAMP_W)) ramp_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (in_valid),
        .mute_i (mute_en),
        .ramp_o (ramp)
    );

    // Scale the table gain by the ramp factor
    always_comb begin
        gr_prod  = {{RAMP_W{1'b0}}, tbl_gain} * {{GAIN_W{1'b0}}, ramp};
        eff_gain = GAIN_W'(gr_prod >> RSH);
    end

    // Stage 1: capture the beat and its effective gain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q    <= 1'b0;
            g1_q    <= '0;
            s1_q[0] <= '0;
            s1_q[1] <= '0;
        end else begin
            v1_q <= in_valid;
            if (in_valid) begin
                g1_q    <= eff_gain;
                s1_q[0] <= in_left;
                s1_q[1] <= in_right;
            end
        end
    end

    // Stage 2: one multiplier per channel, sharing the captured gain
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        vmg_scale #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) scale_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (v1_q),
            .x_i    (s1_q[ch]),
            .gain_i (g1_q),
            .y_o    (y_q[ch])
        );
    end

    // Output strobe follows stage 1
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= v1_q;
    end

    assign out_left  = y_q[0];
    assign out_right = y_q[1];

    // R2
    latency_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    // R2
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);
endmodule

// File: tb/vmg_top_tb.sv
// Bench: behavioural reference model with queues, compared every clock.
module vmg_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [19:0] in_left = '0;
    logic [19:0] in_right = '0;
    logic [5:0]  vol_code = '0;
    logic        mute_en = 1'b0;
    logic        out_valid;
    logic [19:0] out_left;
    logic [19:0] out_right;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit running = 0;
    bit done = 0;
    int model_r = 1024;

    int          due_q[$];
    logic [19:0] el_q[$];
    logic [19:0] er_q[$];
    string       tag_q[$];

    vmg_top dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right), .vol_code(vol_code),
        .mute_en(mute_en), .out_valid(out_valid),
        .out_left(out_left), .out_right(out_right)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Requirement tables: code to dB (R4, R5, R6) and gain recurrence (R3)
    function automatic longint ref_gain(int code);
        int db;
        longint g;
        if (code <= 1) db = 0;
        else if (code <= 51) db = code - 1;
        else if (code == 52 || code == 53) db = 52;
        else if (code == 54 || code == 55) db = 54;
        else if (code == 56 || code == 57) db = 57;
        else if (code <= 60) db = 60;
        else return 0;
        g = 65535;
        for (int i = 0; i < db; i++) g = (g * 58409) / 65536;
        return g;
    endfunction

    function automatic logic [19:0] ref_scale(logic [19:0] x, longint e);
        longint xs;
        longint y;
        xs = longint'($signed(x));
        y = (xs * e + 32768) >>> 16;
        return y[19:0];
    endfunction

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Drive one stereo beat and record its expected result (R8 ramp model)
    task automatic beat(int code, bit mute, logic [19:0] l, logic [19:0] r, string tag);
        longint e;
        @(negedge clk);
        in_valid = 1'b1;
        vol_code = code[5:0];
        mute_en = mute;
        in_left = l;
        in_right = r;
        e = (ref_gain(code) * model_r) / 1024;
        due_q.push_back(cyc + 2);
        el_q.push_back(ref_scale(l, e));
        er_q.push_back(ref_scale(r, e));
        tag_q.push_back(tag);
        if (mute && model_r > 0) model_r--;
        else if (!mute && model_r < 1024) model_r++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            vol_code = 6'd63;
            mute_en = ~mute_en;
        end
    endtask

    // Compare against the model on every clock (R2 timing, data per tag)
    always @(negedge clk) begin
        if (running) begin
            bit exp_v;
            exp_v = (due_q.size() > 0) && (due_q[0] == cyc);
            check(out_valid == exp_v, "R2", "out_valid", out_valid, exp_v);
            if (exp_v) begin
                check(out_left == el_q[0], tag_q[0], "left",
                      longint'($signed(out_left)), longint'($signed(el_q[0])));
                check(out_right == er_q[0], tag_q[0], "right",
                      longint'($signed(out_right)), longint'($signed(er_q[0])));
                void'(due_q.pop_front());
                void'(el_q.pop_front());
                void'(er_q.pop_front());
                void'(tag_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
        check(out_left == '0, "R1", "reset left", out_left, 0);
        check(out_right == '0, "R1", "reset right", out_right, 0);
        rst_n = 1'b1;
        running = 1;
        // R1: first beat at 0 dB unattenuated by the ramp
        beat(0, 0, 20'd400000, 20'hFFFF0, "R1");
        idle(3);
        // R4, R5, R6: sweep every code with full-scale samples
        for (int c = 0; c < 64; c++) begin
            string t;
            t = (c <= 51) ? "R4" : (c <= 57) ? "R5" : "R6";
            beat(c, 0, 20'h7FFFF, 20'h80000, t);
            if (c % 8 == 7) idle(2);
        end
        idle(3);
        // R3: arbitrary samples at several levels
        for (int i = 0; i < 40; i++)
            beat((i % 4) * 13, 0, 20'($urandom), 20'($urandom), "R3");
        // R7: code changes on every back-to-back beat
        for (int i = 0; i < 60; i++)
            beat(int'($urandom_range(0, 63)), 0, 20'($urandom), 20'($urandom), "R7");
        idle(4);
        // R8, R9: start a fade, pause with idle gaps, continue
        for (int i = 0; i < 300; i++) beat(5, 1, 20'($urandom), 20'($urandom), "R8");
        idle(7);
        for (int i = 0; i < 50; i++) begin
            beat(5, 1, 20'($urandom), 20'($urandom), "R9");
            if (i % 10 == 0) idle(3);
        end
        // R10: finish the fade and stay silent
        for (int i = 0; i < 800; i++)
            beat(0, 1, 20'($urandom), 20'($urandom), (model_r == 0) ? "R10" : "R8");
        idle(2);
        // R8: restore volume ramping back up
        for (int i = 0; i < 1100; i++) beat(2, 0, 20'($urandom), 20'($urandom), "R8");
        idle(6);
        check(due_q.size() == 0, "R2", "beats left pending", due_q.size(), 0);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule